// File: doc/BRIEF.md
# Legacy Keyboard Controller Port Emulator

This block lets USB-attached keyboards and mice look like the classic keyboard controller to software that talks to I/O ports 60h (data) and 64h (status and command). It keeps an output byte that emulation software fills for the host to read, a status byte, an input byte that catches whatever the host writes, and a small control register. The control register holds the emulation enable, the interrupt enable and a character-pending flag. From these it drives the keyboard interrupt line, the mouse interrupt line and an interrupt that wakes the emulation software.

There are two access paths. The I/O path carries the legacy side effects. Reading the data port empties the output buffer. Writing either port fills the input buffer and records whether the byte was a command or data. The memory-mapped path gives emulation software plain access to the same registers with no side effects. A command byte D1h on the command port arms a gate-A20 detector. The data byte that follows is absorbed into an A20 output bit and is not reported as input.

Top module: `kbc_port_emu`

## Requirements
- R1: After reset every register reads zero on the memory-mapped path, and irq1, irq12, emu_irq and a20_out are low.
- R2: With emulation enabled, an I/O read of the data port (io_sel_cmd=0) returns the output byte on io_rdata in the same cycle, and from the next cycle the OutputFull bit (status bit 0) is 0.
- R3: With emulation enabled, an I/O read of the command port (io_sel_cmd=1) returns the status byte, with bits 0 OutputFull, 1 InputFull, 2 Flag, 3 CmdData, 4 InhibitSwitch, 5 AuxOutputFull, 6 Time-out and 7 Parity, and it changes no register.
- R4: An I/O write to the data port that is not part of an A20 sequence sets InputFull, clears CmdData and stores the byte in the input register.
- R5: An I/O write to the command port sets CmdData. When the byte is not D1h it also sets InputFull and stores the byte in the input register.
- R6: After a D1h command write, the next I/O data-port write copies bit 1 of its byte to a20_out, clears CmdData, and leaves both InputFull and the input register unchanged. The D1h write itself leaves InputFull and the input register unchanged too.
- R7: irq1 is high exactly while emulation enable, interrupt enable and OutputFull are 1 and AuxOutputFull is 0.
- R8: irq12 is high exactly while emulation enable, interrupt enable, OutputFull and AuxOutputFull are all 1.
- R9: emu_irq is high while emulation is enabled and either InputFull is 1, or OutputFull is 0 with character-pending set.
- R10: Memory-mapped reads and writes touch only the addressed register. Address 0 is the output byte, 1 the status byte, 2 the control register (bit 0 enable, bit 1 character pending, bit 2 interrupt enable), and 3 the input byte. Bits above those widths read as zero.
- R11: With emulation disabled, io_claim stays low, io_rdata is zero, I/O accesses change no register, and all three interrupt outputs are low.
- R12: When an I/O side effect and a memory-mapped write hit the same status bit in the same cycle, the I/O side effect wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | I/O access strobe, one cycle per access |
| io_wr | input | 1 | 1 = I/O write, 0 = I/O read |
| io_sel_cmd | input | 1 | 0 = data port 60h, 1 = command/status port 64h |
| io_wdata | input | 8 | I/O write byte |
| io_rdata | output | 8 | I/O read byte, valid in the request cycle |
| io_claim | output | 1 | The access is claimed by the emulator |
| mm_req | input | 1 | Memory-mapped access strobe |
| mm_wr | input | 1 | 1 = memory-mapped write |
| mm_addr | input | 2 | Register select |
| mm_wdata | input | 32 | Memory-mapped write data |
| mm_rdata | output | 32 | Memory-mapped read data, combinational |
| irq1 | output | 1 | Keyboard interrupt level |
| irq12 | output | 1 | Mouse interrupt level |
| emu_irq | output | 1 | Emulation software interrupt level |
| a20_out | output | 1 | Gate A20 output bit |

## Verification
A status bit left set or cleared wrongly shows up right away. The interrupt lines follow the status byte with no register in between, so it appears on irq1, irq12 or emu_irq in the cycle after the access, and a command-port read shows it in that same cycle. A stuck A20 detector is different. It hides until the next data-port write, which then either raises InputFull when it should not or never moves a20_out. So the bench always follows each access with a read of the status and input registers before the next access.

// File: rtl/kbc_emu_pkg.sv
package kbc_emu_pkg;

  localparam int REG_W  = 32;
  localparam int BYTE_W = 8;
  localparam int CTRL_W = 3;

  // status byte bit positions (visible to legacy software)
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_CMD = 3;
  localparam int ST_AUX = 5;

  // control register bit positions
  localparam int CT_EN    = 0;
  localparam int CT_PEND  = 1;
  localparam int CT_IRQEN = 2;

  typedef enum logic [1:0] {
    MM_OUT  = 2'd0,
    MM_STAT = 2'd1,
    MM_CTRL = 2'd2,
    MM_IN   = 2'd3
  } mm_sel_e;

  typedef struct packed {
    logic rd_data;   // claimed read of data port
    logic rd_stat;   // claimed read of command port
    logic wr_data;   // claimed write of data port
    logic wr_cmd;    // claimed write of command port
    logic set_ibf;   // write that fills the input buffer
    logic a20_load;  // data byte that completes an A20 sequence
  } io_evt_t;

endpackage

// File: rtl/kbc_rst_sync.sv
module kbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/kbc_io_decode.sv
module kbc_io_decode
  import kbc_emu_pkg::*;
#(
  parameter int            PW      = BYTE_W,
  parameter logic [PW-1:0] A20_CMD = 8'hD1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          emu_en,
  input  logic          io_req,
  input  logic          io_wr,
  input  logic          io_sel_cmd,
  input  logic [PW-1:0] io_wdata,
  output logic          io_claim,
  output io_evt_t       evt,
  output logic          a20_armed
);

  logic armed_q, armed_d, armed_en;
  logic wr_hit, rd_hit, is_a20_cmd, is_a20_data;

  always_comb begin
    io_claim    = emu_en & io_req;
    wr_hit      = io_claim & io_wr;
    rd_hit      = io_claim & ~io_wr;
    is_a20_cmd  = wr_hit & io_sel_cmd & (io_wdata == A20_CMD);
    is_a20_data = wr_hit & ~io_sel_cmd & armed_q;

    evt.rd_data  = rd_hit & ~io_sel_cmd;
    evt.rd_stat  = rd_hit & io_sel_cmd;
    evt.wr_data  = wr_hit & ~io_sel_cmd;
    evt.wr_cmd   = wr_hit & io_sel_cmd;
    evt.set_ibf  = wr_hit & ~is_a20_cmd & ~is_a20_data;
    evt.a20_load = is_a20_data;

    // any claimed write re-decides the armed state
    armed_en = wr_hit;
    armed_d  = is_a20_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  assign a20_armed = armed_q;

endmodule

// File: rtl/kbc_regs.sv
module kbc_regs
  import kbc_emu_pkg::*;
#(
  parameter int RW      = REG_W,
  parameter int PW      = BYTE_W,
  parameter int CW      = CTRL_W,
  parameter int A20_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mm_req,
  input  logic          mm_wr,
  input  logic [1:0]    mm_addr,
  input  logic [RW-1:0] mm_wdata,
  input  io_evt_t       evt,
  input  logic [PW-1:0] io_wdata,
  output logic [PW-1:0] out_q,
  output logic [PW-1:0] stat_q,
  output logic [CW-1:0] ctrl_q,
  output logic          a20_q,
  output logic [RW-1:0] mm_rdata
);

  localparam int PAD_B = RW - PW;
  localparam int PAD_C = RW - CW;

  logic [PW-1:0] out_d, stat_d, in_d, in_q;
  logic [CW-1:0] ctrl_d;
  logic          a20_d;
  logic          out_en, stat_en, ctrl_en, in_en, a20_en;
  logic          mm_wr_hit;
  mm_sel_e       sel;
  logic          unused_bits;

  assign unused_bits = ^{mm_wdata[RW-1:PW], evt.rd_stat};

  always_comb begin
    sel       = mm_sel_e'(mm_addr);
    mm_wr_hit = mm_req & mm_wr;

    out_d  = out_q;
    stat_d = stat_q;
    ctrl_d = ctrl_q;
    in_d   = in_q;
    a20_d  = a20_q;

    out_en  = 1'b0;
    stat_en = 1'b0;
    ctrl_en = 1'b0;
    in_en   = 1'b0;
    a20_en  = 1'b0;

    // plain register path first
    if (mm_wr_hit) begin
      unique case (sel)
        MM_OUT:  begin out_d  = mm_wdata[PW-1:0]; out_en  = 1'b1; end
        MM_STAT: begin stat_d = mm_wdata[PW-1:0]; stat_en = 1'b1; end
        MM_CTRL: begin ctrl_d = mm_wdata[CW-1:0]; ctrl_en = 1'b1; end
        MM_IN:   begin in_d   = mm_wdata[PW-1:0]; in_en   = 1'b1; end
        default: ;
      endcase
    end

    // I/O side effects override on the bits they touch
    if (evt.rd_data) begin
      stat_d[ST_OBF] = 1'b0;
      stat_en        = 1'b1;
    end
    if (evt.wr_data) begin
      stat_d[ST_CMD] = 1'b0;
      stat_en        = 1'b1;
    end
    if (evt.wr_cmd) begin
      stat_d[ST_CMD] = 1'b1;
      stat_en        = 1'b1;
    end
    if (evt.set_ibf) begin
      stat_d[ST_IBF] = 1'b1;
      stat_en        = 1'b1;
      in_d           = io_wdata;
      in_en          = 1'b1;
    end
    if (evt.a20_load) begin
      a20_d  = io_wdata[A20_BIT];
      a20_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      stat_q <= '0;
      ctrl_q <= '0;
      in_q   <= '0;
      a20_q  <= 1'b0;
    end else begin
      if (out_en)  out_q  <= out_d;
      if (stat_en) stat_q <= stat_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (in_en)   in_q   <= in_d;
      if (a20_en)  a20_q  <= a20_d;
    end
  end

  always_comb begin
    unique case (sel)
      MM_OUT:  mm_rdata = {{PAD_B{1'b0}}, out_q};
      MM_STAT: mm_rdata = {{PAD_B{1'b0}}, stat_q};
      MM_CTRL: mm_rdata = {{PAD_C{1'b0}}, ctrl_q};
      MM_IN:   mm_rdata = {{PAD_B{1'b0}}, in_q};
      default: mm_rdata = '0;
    endcase
  end

endmodule

// File: rtl/kbc_irq_gen.sv
module kbc_irq_gen
  import kbc_emu_pkg::*;
#(
  parameter int PW = BYTE_W,
  parameter int CW = CTRL_W
) (
  input  logic [PW-1:0] stat,
  input  logic [CW-1:0] ctrl,
  output logic          irq1,
  output logic          irq12,
  output logic          emu_irq
);

  logic en, obf_irq;

  always_comb begin
    en      = ctrl[CT_EN];
    obf_irq = en & ctrl[CT_IRQEN] & stat[ST_OBF];
    irq1    = obf_irq & ~stat[ST_AUX];
    irq12   = obf_irq & stat[ST_AUX];
    emu_irq = en & (stat[ST_IBF] | (~stat[ST_OBF] & ctrl[CT_PEND]));
  end

endmodule

// File: rtl/kbc_port_emu.sv
module kbc_port_emu
  import kbc_emu_pkg::*;
#(
  parameter int            RW        = REG_W,
  parameter int            PW        = BYTE_W,
  parameter int            CW        = CTRL_W,
  parameter logic [PW-1:0] A20_CMD   = 8'hD1,
  parameter int            A20_BIT   = 1,
  parameter int            RST_STAGE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_req,
  input  logic          io_wr,
  input  logic          io_sel_cmd,
  input  logic [PW-1:0] io_wdata,
  output logic [PW-1:0] io_rdata,
  output logic          io_claim,
  input  logic          mm_req,
  input  logic          mm_wr,
  input  logic [1:0]    mm_addr,
  input  logic [RW-1:0] mm_wdata,
  output logic [RW-1:0] mm_rdata,
  output logic          irq1,
  output logic          irq12,
  output logic          emu_irq,
  output logic          a20_out
);

  logic          rst_sync_n;
  io_evt_t       evt;
  logic          a20_armed;
  logic [PW-1:0] out_q, stat_q;
  logic [CW-1:0] ctrl_q;
  logic          emu_en;

  assign emu_en = ctrl_q[CT_EN];

  kbc_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  kbc_io_decode #(.PW(PW), .A20_CMD(A20_CMD)) u_dec (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .emu_en     (emu_en),
    .io_req     (io_req),
    .io_wr      (io_wr),
    .io_sel_cmd (io_sel_cmd),
    .io_wdata   (io_wdata),
    .io_claim   (io_claim),
    .evt        (evt),
    .a20_armed  (a20_armed)
  );

  kbc_regs #(.RW(RW), .PW(PW), .CW(CW), .A20_BIT(A20_BIT)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .mm_req   (mm_req),
    .mm_wr    (mm_wr),
    .mm_addr  (mm_addr),
    .mm_wdata (mm_wdata),
    .evt      (evt),
    .io_wdata (io_wdata),
    .out_q    (out_q),
    .stat_q   (stat_q),
    .ctrl_q   (ctrl_q),
    .a20_q    (a20_out),
    .mm_rdata (mm_rdata)
  );

  kbc_irq_gen #(.PW(PW), .CW(CW)) u_irq (
    .stat    (stat_q),
    .ctrl    (ctrl_q),
    .irq1    (irq1),
    .irq12   (irq12),
    .emu_irq (emu_irq)
  );

  always_comb begin
    if (evt.rd_data)      io_rdata = out_q;
    else if (evt.rd_stat) io_rdata = stat_q;
    else                  io_rdata = '0;
  end

endmodule

// File: rtl/kbc_emu_checker.sv
module kbc_emu_checker #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          io_wr,
  input logic          io_sel_cmd,
  input logic          io_claim,
  input logic          mm_req,
  input logic          mm_wr,
  input logic [1:0]    mm_addr,
  input logic          irq1,
  input logic          irq12,
  input logic          emu_irq,
  input logic          emu_en,
  input logic [PW-1:0] stat_q,
  input logic          a20_armed
);

  // R11: nothing claimed while emulation is off
  a_r11_no_claim_off: assert property (@(posedge clk) disable iff (!rst_n)
    !emu_en |-> !io_claim);

  // R11: interrupt lines quiet while emulation is off
  a_r11_irq_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
    !emu_en |-> !(irq1 || irq12 || emu_irq));

  // R7 / R8: one legacy line at a time
  a_r8_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq1 && irq12));

  // R8: mouse line needs a full aux buffer
  a_r8_irq12_aux: assert property (@(posedge clk) disable iff (!rst_n)
    irq12 |-> (stat_q[0] && stat_q[5]));

  // R2: data-port read empties the output buffer
  a_r2_obf_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (io_claim && !io_wr && !io_sel_cmd) |=> !stat_q[0]);

  // R4: plain data write fills input, marks data
  a_r4_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    (io_claim && io_wr && !io_sel_cmd && !a20_armed) |=> (stat_q[1] && !stat_q[3]));

  // R5: command write marks command
  a_r5_cmd_write: assert property (@(posedge clk) disable iff (!rst_n)
    (io_claim && io_wr && io_sel_cmd) |=> stat_q[3]);

  // R6: A20 data byte leaves InputFull alone
  a_r6_a20_no_ibf: assert property (@(posedge clk) disable iff (!rst_n)
    (io_claim && io_wr && !io_sel_cmd && a20_armed &&
     !(mm_req && mm_wr && mm_addr == 2'd1)) |=> $stable(stat_q[1]));

  // R10: plain register reads have no side effect
  a_r10_mm_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_req && !mm_wr && !io_claim) |=> $stable(stat_q));

endmodule

bind kbc_port_emu kbc_emu_checker #(.PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_wr      (io_wr),
  .io_sel_cmd (io_sel_cmd),
  .io_claim   (io_claim),
  .mm_req     (mm_req),
  .mm_wr      (mm_wr),
  .mm_addr    (mm_addr),
  .irq1       (irq1),
  .irq12      (irq12),
  .emu_irq    (emu_irq),
  .emu_en     (emu_en),
  .stat_q     (stat_q),
  .a20_armed  (a20_armed)
);

// File: tb/test_kbc_port_emu.sv
`timescale 1ns/1ps
module test_kbc_port_emu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_req, io_wr, io_sel_cmd;
  logic [7:0]  io_wdata, io_rdata;
  logic        io_claim;
  logic        mm_req, mm_wr;
  logic [1:0]  mm_addr;
  logic [31:0] mm_wdata, mm_rdata;
  logic        irq1, irq12, emu_irq, a20_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  kbc_port_emu i_kbc_port_emu (
    .clk(clk), .rst_n(rst_n),
    .io_req(io_req), .io_wr(io_wr), .io_sel_cmd(io_sel_cmd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_claim(io_claim),
    .mm_req(mm_req), .mm_wr(mm_wr), .mm_addr(mm_addr),
    .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
    .irq1(irq1), .irq12(irq12), .emu_irq(emu_irq), .a20_out(a20_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mm_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    mm_req = 1'b1; mm_wr = 1'b1; mm_addr = a; mm_wdata = d;
    @(negedge clk);
    mm_req = 1'b0; mm_wr = 1'b0;
    #1;
  endtask

  task automatic mm_read(input logic [1:0] a, output logic [31:0] d);
    mm_req = 1'b1; mm_wr = 1'b0; mm_addr = a;
    #1 d = mm_rdata;
    mm_req = 1'b0;
    #1;
  endtask

  task automatic io_acc(input logic sel, input logic wr, input logic [7:0] d,
                        output logic [7:0] rd, output logic cl);
    @(negedge clk);
    io_req = 1'b1; io_wr = wr; io_sel_cmd = sel; io_wdata = d;
    #1 rd = io_rdata; cl = io_claim;
    @(negedge clk);
    io_req = 1'b0; io_wr = 1'b0;
    #1;
  endtask

  task automatic expect_reg(input string req, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    mm_read(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    expect_reg("R1 out", 2'd0, 0);
    expect_reg("R1 stat", 2'd1, 0);
    expect_reg("R1 ctrl", 2'd2, 0);
    expect_reg("R1 in", 2'd3, 0);
    chk("R1 irqs", {irq1, irq12, emu_irq, a20_out}, 0);
  endtask

  task automatic t_disabled();
    logic [7:0] rd; logic cl;
    mm_write(2'd0, 32'h77);
    io_acc(1'b0, 1'b1, 8'h12, rd, cl);
    chk("R11 claim", cl, 0);
    expect_reg("R11 stat", 2'd1, 0);
    expect_reg("R11 in", 2'd3, 0);
    mm_write(2'd1, 32'h01);
    io_acc(1'b0, 1'b0, 8'h00, rd, cl);
    chk("R11 rdata", rd, 0);
    expect_reg("R11 obf kept", 2'd1, 32'h01);
    chk("R11 irqs", {irq1, irq12, emu_irq}, 0);
  endtask

  task automatic t_out_read();
    logic [7:0] rd; logic cl;
    mm_write(2'd2, 32'h5);
    mm_write(2'd0, 32'hA5);
    mm_write(2'd1, 32'h01);
    chk("R7 irq1 on", {irq1, irq12}, 2'b10);
    io_acc(1'b0, 1'b0, 8'h00, rd, cl);
    chk("R2 rdata", rd, 8'hA5);
    chk("R2 claim", cl, 1);
    expect_reg("R2 obf clear", 2'd1, 0);
    chk("R7 irq1 off", irq1, 0);
  endtask

  task automatic t_aux();
    mm_write(2'd1, 32'h21);
    chk("R8 irq12 on", {irq1, irq12}, 2'b01);
    mm_write(2'd2, 32'h1);
    chk("R8 irq12 needs enable", irq12, 0);
    mm_write(2'd2, 32'h5);
  endtask

  task automatic t_status_read();
    logic [7:0] rd; logic cl;
    mm_write(2'd1, 32'hD4);
    io_acc(1'b1, 1'b0, 8'h00, rd, cl);
    chk("R3 rdata", rd, 8'hD4);
    expect_reg("R3 no change", 2'd1, 32'hD4);
  endtask

  task automatic t_io_write();
    logic [7:0] rd; logic cl;
    mm_write(2'd1, 32'h08);
    io_acc(1'b0, 1'b1, 8'h3C, rd, cl);
    expect_reg("R4 stat", 2'd1, 32'h02);
    expect_reg("R4 in", 2'd3, 32'h3C);
    chk("R9 emu_irq ibf", emu_irq, 1);
    mm_write(2'd1, 32'h00);
    chk("R9 emu_irq idle", emu_irq, 0);
    io_acc(1'b1, 1'b1, 8'hAA, rd, cl);
    expect_reg("R5 stat", 2'd1, 32'h0A);
    expect_reg("R5 in", 2'd3, 32'hAA);
  endtask

  task automatic t_charpend();
    mm_write(2'd1, 32'h00);
    mm_write(2'd2, 32'h7);
    chk("R9 pending empty", emu_irq, 1);
    mm_write(2'd1, 32'h01);
    chk("R9 pending full", emu_irq, 0);
    mm_write(2'd2, 32'h5);
  endtask

  task automatic t_a20();
    logic [7:0] rd; logic cl;
    mm_write(2'd1, 32'h00);
    io_acc(1'b1, 1'b1, 8'hD1, rd, cl);
    expect_reg("R6 cmd stat", 2'd1, 32'h08);
    expect_reg("R6 cmd in", 2'd3, 32'hAA);
    io_acc(1'b0, 1'b1, 8'h02, rd, cl);
    chk("R6 a20 set", a20_out, 1);
    expect_reg("R6 data stat", 2'd1, 32'h00);
    expect_reg("R6 data in", 2'd3, 32'hAA);
    io_acc(1'b0, 1'b1, 8'h55, rd, cl);
    expect_reg("R6 disarmed", 2'd1, 32'h02);
    expect_reg("R6 normal in", 2'd3, 32'h55);
    chk("R6 a20 kept", a20_out, 1);
    io_acc(1'b1, 1'b1, 8'hD1, rd, cl);
    io_acc(1'b0, 1'b1, 8'hFD, rd, cl);
    chk("R6 a20 clear", a20_out, 0);
  endtask

  task automatic t_mm_quiet();
    logic [31:0] v;
    mm_write(2'd1, 32'h03);
    mm_read(2'd0, v);
    mm_read(2'd3, v);
    @(negedge clk); #1;
    expect_reg("R10 stat kept", 2'd1, 32'h03);
    mm_write(2'd0, 32'hFFFF_FFFF);
    expect_reg("R10 out width", 2'd0, 32'hFF);
    expect_reg("R10 ctrl width", 2'd2, 32'h5);
  endtask

  task automatic t_priority();
    mm_write(2'd1, 32'h01);
    @(negedge clk);
    mm_req = 1'b1; mm_wr = 1'b1; mm_addr = 2'd1; mm_wdata = 32'h01;
    io_req = 1'b1; io_wr = 1'b0; io_sel_cmd = 1'b0;
    @(negedge clk);
    mm_req = 1'b0; mm_wr = 1'b0; io_req = 1'b0;
    #1;
    expect_reg("R12 read wins", 2'd1, 32'h00);
    @(negedge clk);
    mm_req = 1'b1; mm_wr = 1'b1; mm_addr = 2'd1; mm_wdata = 32'h08;
    io_req = 1'b1; io_wr = 1'b1; io_sel_cmd = 1'b0; io_wdata = 8'h44;
    @(negedge clk);
    mm_req = 1'b0; mm_wr = 1'b0; io_req = 1'b0; io_wr = 1'b0;
    #1;
    expect_reg("R12 write wins", 2'd1, 32'h02);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    io_req = 1'b0; io_wr = 1'b0; io_sel_cmd = 1'b0; io_wdata = '0;
    mm_req = 1'b0; mm_wr = 1'b0; mm_addr = '0; mm_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_disabled();
    t_out_read();
    t_aux();
    t_status_read();
    t_io_write();
    t_charpend();
    t_a20();
    t_mm_quiet();
    t_priority();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule